// File: doc/BRIEF.md
# Windowed Horizontal Sync Filter

The block cleans a raw horizontal sync stream sampled on a fixed reference clock. Sync pulses are active high and the rising edge is the leading edge. The block learns the line period from leading edges it has accepted, predicts where the next one is due and opens an acceptance window of plus or minus `win_i` reference ticks around that point. Edges outside the window are dropped. This removes serration pulses, equalising pulses and mid-line glitches, where a debouncer would only shorten them. With a 27 MHz reference one window unit is about 37 ns. Typical settings are 0x88 for standard-definition timing, 0x44 for extended definition, 0x0E for high definition and 0x03 for PC timing.

Once the filter has locked, a line whose edge never arrives is bridged by a synthetic pulse. The filter stops bridging after two such lines, drops lock and goes back to acquisition. With `en_i` low the filter is bypassed.

Top module: `hsync_window_filter`

## Requirements
- R1: After reset, `hs_o` and `lock_o` are low.
- R2: While `en_i` is low, `hs_o` equals `hs_raw_i` delayed by one register and `lock_o` is low from the next cycle. All tracking state is cleared, so the first rising edge after re-enabling is accepted as in R3.
- R3: With no reference, the first rising edge of `hs_raw_i` is accepted unconditionally. The next rising edge is also accepted unconditionally, and its distance in clock cycles from the first becomes the predicted period P.
- R4: Once P is known, a rising edge at distance d from the last reference point is accepted only if |d - P| <= `win_i`. Any other rising edge produces no output pulse.
- R5: Each accepted in-window edge becomes the new reference point and replaces P with its own distance d.
- R6: `lock_o` rises in the cycle after the second consecutive in-window edge that follows the period measurement.
- R7: An accepted edge starts an output pulse that is visible on the sampling edge where the raw rise is first seen. The pulse lasts as many cycles as the raw pulse stays high, capped at floor(P/2) cycles. There is no cap while P is unknown.
- R8: While locked, if d reaches P + `win_i` + 1 with no accepted edge, a synthetic pulse starts on that cycle. Its width is that of the last pulse taken from the raw input. The reference point moves to where the predicted edge should have been. At most 2 such pulses are emitted in a row.
- R9: A third consecutive missing edge while locked clears `lock_o` without a pulse and returns the filter to acquisition. Likewise, an unlocked window that closes with no edge returns the filter to acquisition.
- R10: With `win_i` = 0, only an edge at exactly d = P is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one tick is one window unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Filter enable; low selects bypass |
| win_i | input | WIN_W (8) | Window half-width in reference ticks |
| hs_raw_i | input | 1 | Raw horizontal sync, active high |
| hs_o | output | 1 | Filtered horizontal sync |
| lock_o | output | 1 | Line period tracked and confirmed |

## Verification
The assertions assume the following about the inputs:
- Each raw sync pulse falls well before the next line's window opens.
- The window half-width is small against half the line period.
- `win_i` and `en_i` change only between lines, never inside a pulse or a window.

The stimulus is built line by line under these assumptions. Line lengths run from 59 to 105 ticks, pulses are at most 40 ticks wide, glitches sit mid-line and are at most a few ticks long, and the window is 4 or 0. Setting changes are driven only at line boundaries.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MEAS  = 2'd1,
    ST_TRACK = 2'd2
  } acq_state_e;
endpackage

// File: rtl/hsf_predict.sv
module hsf_predict #(
  parameter int CNT_W = 12,
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             load_i,
  input  logic             realign_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] per_o,
  output logic             in_win_o,
  output logic             past_win_o
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] pos_q, per_q;
  logic [EW-1:0]    pos_e, per_e, win_e, hi_e;
  logic             sat;

  assign pos_e = {1'b0, pos_q};
  assign per_e = {1'b0, per_q};
  assign win_e = EW'(win_i);
  assign hi_e  = per_e + win_e;
  assign sat   = &pos_q;

  assign in_win_o   = ((pos_e + win_e) >= per_e) && (pos_e <= hi_e);
  assign past_win_o = (pos_e > hi_e) || sat;
  assign per_o      = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      per_q <= '0;
    end else if (clr_i) begin
      pos_q <= '0;
      per_q <= '0;
    end else if (take_i) begin
      pos_q <= CNT_W'(1);
      if (load_i) per_q <= pos_q;
    end else if (realign_i) begin
      // place reference where the predicted edge was due
      pos_q <= CNT_W'(win_i) + CNT_W'(2);
    end else if (!sat) begin
      pos_q <= pos_q + CNT_W'(1);
    end
  end

  // R4
  win_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_win_o && !sat) |-> !in_win_o);
endmodule

// File: rtl/hsf_ctrl.sv
module hsf_ctrl #(
  parameter int LOCK_N  = 2,
  parameter int COAST_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic in_win_i,
  input  logic past_win_i,
  output logic take_o,
  output logic load_o,
  output logic synth_o,
  output logic have_per_o,
  output logic lock_o
);
  import hsf_pkg::*;

  localparam int GW = $clog2(LOCK_N + 1);
  localparam int CW = $clog2(COAST_N + 1);

  acq_state_e    state_q;
  logic [GW-1:0] good_q;
  logic [CW-1:0] miss_q;
  logic          lock_q;
  logic          hit;

  assign hit        = rise_i && in_win_i;
  assign take_o     = en_i && rise_i && ((state_q != ST_TRACK) || in_win_i);
  assign load_o     = take_o && (state_q != ST_IDLE);
  assign synth_o    = en_i && (state_q == ST_TRACK) && !hit && past_win_i &&
                      lock_q && (miss_q < CW'(COAST_N));
  assign have_per_o = (state_q == ST_TRACK);
  assign lock_o     = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      good_q  <= '0;
      miss_q  <= '0;
      lock_q  <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      good_q  <= '0;
      miss_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise_i) state_q <= ST_MEAS;
        ST_MEAS: if (rise_i) begin
          state_q <= ST_TRACK;
          good_q  <= '0;
          miss_q  <= '0;
          lock_q  <= 1'b0;
        end
        ST_TRACK: begin
          if (hit) begin
            miss_q <= '0;
            if (!lock_q) begin
              if (good_q == GW'(LOCK_N - 1)) lock_q <= 1'b1;
              else                           good_q <= good_q + GW'(1);
            end
          end else if (past_win_i) begin
            if (synth_o) begin
              miss_q <= miss_q + CW'(1);
            end else begin
              state_q <= ST_IDLE;
              lock_q  <= 1'b0;
              miss_q  <= '0;
              good_q  <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  miss_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q <= CW'(COAST_N));
  // R6
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(take_o));
  // R6
  lock_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (state_q == ST_TRACK));
  // R9
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_q) && $past(en_i)) |-> $past(past_win_i));
endmodule

// File: rtl/hsf_pulse.sv
module hsf_pulse #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             raw_i,
  input  logic             start_i,
  input  logic             synth_i,
  input  logic             have_per_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             hs_o
);
  logic [CNT_W-1:0] pw_q, wid_q, half, lim;
  logic             pact_q, follow_q, done;

  assign half = per_i >> 1;
  assign lim  = !have_per_i ? '1 : ((half == '0) ? CNT_W'(1) : half);
  assign done = (follow_q && !raw_i) || (pw_q >= lim) ||
                (!follow_q && (pw_q >= wid_q));
  assign hs_o = pact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pact_q   <= 1'b0;
      follow_q <= 1'b0;
      pw_q     <= '0;
      wid_q    <= CNT_W'(1);
    end else if (!en_i) begin
      pact_q   <= raw_i;
      follow_q <= 1'b0;
      pw_q     <= '0;
    end else if (start_i) begin
      pact_q   <= 1'b1;
      follow_q <= 1'b1;
      pw_q     <= CNT_W'(1);
    end else if (synth_i) begin
      pact_q   <= 1'b1;
      follow_q <= 1'b0;
      pw_q     <= CNT_W'(1);
    end else if (pact_q) begin
      if (done) begin
        pact_q <= 1'b0;
        if (follow_q) wid_q <= pw_q;
      end else begin
        pw_q <= pw_q + CNT_W'(1);
      end
    end
  end

  // R7
  width_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pact_q && have_per_i) |-> (pw_q <= lim));
endmodule

// File: rtl/hsync_window_filter.sv
module hsync_window_filter #(
  parameter int CNT_W   = 12,
  parameter int WIN_W   = 8,
  parameter int LOCK_N  = 2,
  parameter int COAST_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             hs_raw_i,
  output logic             hs_o,
  output logic             lock_o
);
  logic             raw_q, rise;
  logic             take, load, synth, have_per, in_win, past_win;
  logic [CNT_W-1:0] per;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= hs_raw_i;
  end

  assign rise = hs_raw_i && !raw_q;

  hsf_predict #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_predict (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!en_i),
    .take_i     (take),
    .load_i     (load),
    .realign_i  (synth),
    .win_i      (win_i),
    .per_o      (per),
    .in_win_o   (in_win),
    .past_win_o (past_win)
  );

  hsf_ctrl #(.LOCK_N(LOCK_N), .COAST_N(COAST_N)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .rise_i     (rise),
    .in_win_i   (in_win),
    .past_win_i (past_win),
    .take_o     (take),
    .load_o     (load),
    .synth_o    (synth),
    .have_per_o (have_per),
    .lock_o     (lock_o)
  );

  hsf_pulse #(.CNT_W(CNT_W)) i_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .raw_i      (hs_raw_i),
    .start_i    (take),
    .synth_i    (synth),
    .have_per_i (have_per),
    .per_i      (per),
    .hs_o       (hs_o)
  );

  // R2
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hs_o == $past(hs_raw_i)));
  // R2
  lock_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lock_o);
  // R4
  track_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && have_per) |-> in_win);
endmodule

// File: tb/test_hsync_window_filter.sv
`timescale 1ns/1ps
module test_hsync_window_filter;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       en;
  logic [7:0] win;
  logic       hs_raw;
  logic       hs_o, lock_o;

  int nchk = 0;
  int nerr = 0;
  int hi, first, nr;
  int rof[4];
  logic prev_hs;

  always #10 clk = ~clk;

  hsync_window_filter i_hsync_window_filter (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .win_i    (win),
    .hs_raw_i (hs_raw),
    .hs_o     (hs_o),
    .lock_o   (lock_o)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // one line starting at a raw rise; sample hs_o after each edge
  task automatic seg(input int n, input int w, input int ga, input int gw);
    hi = 0; first = -1; nr = 0;
    for (int k = 0; k < n; k++) begin
      hs_raw = (k < w) || (gw > 0 && k >= ga && k < ga + gw);
      @(negedge clk);
      if (hs_o) begin
        hi++;
        if (first < 0) first = k;
      end
      if (hs_o && !prev_hs) begin
        if (nr < 4) rof[nr] = k;
        nr++;
      end
      prev_hs = hs_o;
    end
  endtask

  task automatic line_ok(input string req, input int exp_hi, input int exp_lock);
    chk(req, "first", first, 0);
    chk(req, "width", hi, exp_hi);
    chk(req, "pulses", nr, 1);
    chk(req, "lock", int'(lock_o), exp_lock);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; en = 1'b0; win = 8'd4; hs_raw = 1'b0; prev_hs = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "hs_o", int'(hs_o), 0);
    chk("R1", "lock", int'(lock_o), 0);
    rst_ni = 1'b1; en = 1'b1;
    seg(10, 0, 0, 0);

    // acquisition, P = 100
    seg(100, 8, 0, 0);  line_ok("R3", 8, 0);
    seg(100, 8, 0, 0);  line_ok("R3", 8, 0);
    seg(100, 8, 40, 3); line_ok("R4", 8, 0);  // mid-line glitch dropped
    seg(100, 8, 0, 0);  line_ok("R6", 8, 1);

    // window boundary sweep, win = 4
    for (int dl = -4; dl <= 4; dl++) begin
      seg(100 + dl, 8, 0, 0); line_ok("R5", 8, 1);
      seg(100, 8, 0, 0);      line_ok("R4", 8, 1);
    end

    // early edge at d = 95 is dropped; synthetic pulse when window closes at 105
    seg(95, 8, 0, 0);  line_ok("R4", 8, 1);
    seg(105, 8, 0, 0);
    chk("R8", "synth first", first, 10);
    chk("R8", "synth width", hi, 8);
    chk("R8", "synth pulses", nr, 1);
    chk("R8", "lock", int'(lock_o), 1);

    // realigned reference: next edge on time; then line drops out
    seg(400, 8, 0, 0);
    chk("R8", "pulses", nr, 3);
    chk("R8", "coast1 at", rof[1], 105);
    chk("R8", "coast2 at", rof[2], 205);
    chk("R8", "width", hi, 24);
    chk("R9", "lock dropped", int'(lock_o), 0);

    // reacquire at P = 60, cap at P/2
    seg(60, 8, 0, 0);  line_ok("R9", 8, 0);
    seg(60, 8, 0, 0);  line_ok("R3", 8, 0);
    seg(60, 40, 0, 0); line_ok("R7", 30, 0);
    seg(60, 8, 0, 0);  line_ok("R6", 8, 1);

    // zero window
    win = 8'd0;
    seg(60, 8, 0, 0);  line_ok("R10", 8, 1);
    seg(59, 8, 0, 0);  line_ok("R10", 8, 1);
    seg(61, 8, 0, 0);
    chk("R10", "synth first", first, 2);
    chk("R10", "synth width", hi, 8);
    seg(60, 8, 0, 0);  line_ok("R10", 8, 1);

    // bypass
    en = 1'b0;
    seg(30, 5, 10, 2);
    chk("R2", "first", first, 0);
    chk("R2", "width", hi, 7);
    chk("R2", "pulses", nr, 2);
    chk("R2", "lock", int'(lock_o), 0);
    en = 1'b1; win = 8'd4;
    seg(50, 8, 0, 0);  line_ok("R2", 8, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule